// File: doc/BRIEF.md
# MSI capture and interrupt aggregator

This block receives message-signalled interrupts for a root-port style controller and folds them into one level-sensitive interrupt line. Software programs a 64-bit capture address and a 32-vector bank made of an enable word, a mask word and a pending-status word. The block watches an inbound bus write port. A full 32-bit write to the programmed address is taken as a vector number, not as data to store. If that vector is enabled, its status bit is set.

The interrupt line is driven by a two-state machine. In `IRQ_IDLE` the line is low. The RAISE transition to `IRQ_ASSERTED` happens when a capture leaves at least one pending vector whose mask bit is clear. The mask used is the one in force in the capture cycle. The CLEAR transition back to `IRQ_IDLE` happens only when a software write to the status word leaves the whole word at zero. Neither a mask change nor any other event moves the machine.

Software reaches the registers through a simple 32-bit port. Writes take effect at the clock edge. Reads are combinational from the presented offset.

Top module: `msi_irq_collector`

## Requirements
- R1: After reset the status, enable, mask and both address halves read zero and `irq` is low.
- R2: A write to offset 0x10 replaces the low 32 bits of the capture address. A write to offset 0x14 replaces the high 32 bits. Each write leaves the other half unchanged, and both halves read back what was written.
- R3: An inbound write with `in_valid` high, `in_size` equal to 4, `in_addr` equal to the capture address and `in_data` equal to V (0 to 31) sets status bit V when enable bit V is 1. The status word sits at offset 0x00.
- R4: No capture happens when enable bit V is 0. No capture of any vector happens while the enable word (offset 0x04) is all zero.
- R5: An inbound write is ignored when its data is 32 or more, its size is not 4 bytes, or its address differs from the capture address in any bit.
- R6: `irq` rises at the clock edge of a capture when the status after that capture has a set bit whose mask bit is clear. Only a capture can raise `irq`.
- R7: A capture of a masked vector (mask word at offset 0x08, bit set = masked) sets its status bit but does not raise `irq`.
- R8: A software write to the status word toggles every status bit whose written data bit is 1.
- R9: `irq` falls only at a status write that leaves the status word entirely zero. A partial clear and a mask change leave `irq` unchanged.
- R10: When a capture and a status write hit the same edge, the toggle is applied first and the captured bit is then set.
- R11: Reads of an offset outside the five registers return zero. Writes to such an offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 8 | Register byte offset |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data for `sw_addr` |
| in_valid | input | 1 | Inbound bus write valid |
| in_addr | input | 64 | Inbound write address |
| in_size | input | 3 | Inbound write size in bytes |
| in_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Aggregated level interrupt |

## Verification
The assertions watch, on every cycle, the status arithmetic and the interrupt edges. They check that a capture sets its bit, that a lone status write is a pure toggle, and that a combined write toggles first and then sets. They also check that an all-zero enable word freezes status, that the line rises after a qualifying capture, that it never rises without a capture, and that it falls only after a status write. The bench scenarios are the only place that shows the decode side. That covers the exact address match, size and range rejection, per-vector enable gating, the register offsets and half-word address writes. The scenarios also show the sticky nature of the line across mask changes and partial clears.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;

    localparam logic [7:0] OFS_STATUS  = 8'h00;
    localparam logic [7:0] OFS_ENABLE  = 8'h04;
    localparam logic [7:0] OFS_MASK    = 8'h08;
    localparam logic [7:0] OFS_ADDR_LO = 8'h10;
    localparam logic [7:0] OFS_ADDR_HI = 8'h14;

    localparam logic [2:0] FULL_WORD_BYTES = 3'd4;

    typedef enum logic [0:0] {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic status;
        logic enable;
        logic mask;
        logic addr_lo;
        logic addr_hi;
    } reg_sel_t;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_irq_pkg::*;
#(
    parameter int unsigned REG_AW = 8
) (
    input  logic              sw_we,
    input  logic [REG_AW-1:0] sw_addr,
    output reg_sel_t          rd_sel,
    output reg_sel_t          wr_sel
);

    always_comb begin
        rd_sel.status  = (sw_addr == REG_AW'(OFS_STATUS));
        rd_sel.enable  = (sw_addr == REG_AW'(OFS_ENABLE));
        rd_sel.mask    = (sw_addr == REG_AW'(OFS_MASK));
        rd_sel.addr_lo = (sw_addr == REG_AW'(OFS_ADDR_LO));
        rd_sel.addr_hi = (sw_addr == REG_AW'(OFS_ADDR_HI));
        wr_sel         = sw_we ? rd_sel : '0;
    end

endmodule

// File: rtl/msi_addr_match.sv
module msi_addr_match
    import msi_irq_pkg::*;
#(
    parameter int unsigned AW   = 64,
    parameter int unsigned DW   = 32,
    parameter int unsigned NVEC = 32
) (
    input  logic            in_valid,
    input  logic [AW-1:0]   in_addr,
    input  logic [2:0]      in_size,
    input  logic [DW-1:0]   in_data,
    input  logic [AW-1:0]   win_base,
    input  logic [NVEC-1:0] enable_q,
    output logic [NVEC-1:0] cap_onehot
);

    logic window_open;
    logic accept;

    // The window is live only while some vector is enabled.
    assign window_open = |enable_q;
    assign accept      = in_valid && window_open &&
                         (in_addr == win_base) &&
                         (in_size == FULL_WORD_BYTES);

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        assign cap_onehot[v] = accept && (in_data == DW'(v)) && enable_q[v];
    end

endmodule

// File: rtl/msi_vector_bank.sv
module msi_vector_bank #(
    parameter int unsigned NVEC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic            mask_we,
    input  logic            stat_we,
    input  logic [NVEC-1:0] wdata,
    input  logic [NVEC-1:0] cap_onehot,
    output logic [NVEC-1:0] enable_q,
    output logic [NVEC-1:0] mask_q,
    output logic [NVEC-1:0] status_q,
    output logic [NVEC-1:0] status_d
);

    logic [NVEC-1:0] toggled;

    // Software toggle first, capture on top of it.
    assign toggled  = stat_we ? (status_q ^ wdata) : status_q;
    assign status_d = toggled | cap_onehot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (en_we)   enable_q <= wdata;
            if (mask_we) mask_q   <= wdata;
            status_q <= status_d;
        end
    end

    p_capture_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_onehot != '0) |=> ((status_q & $past(cap_onehot)) == $past(cap_onehot)));

    p_window_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0 && !stat_we) |=> $stable(status_q));

    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && cap_onehot == '0) |=> (status_q == ($past(status_q) ^ $past(wdata))));

    p_flip_then_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && cap_onehot != '0) |=>
        (status_q == (($past(status_q) ^ $past(wdata)) | $past(cap_onehot))));

endmodule

// File: rtl/msi_irq_fsm.sv
module msi_irq_fsm
    import msi_irq_pkg::*;
#(
    parameter int unsigned NVEC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_any,
    input  logic            stat_we,
    input  logic [NVEC-1:0] status_d,
    input  logic [NVEC-1:0] mask_q,
    output logic            irq
);

    irq_state_e state_q, state_d;
    logic       raise_ev;
    logic       clear_ev;

    assign raise_ev = cap_any && ((status_d & ~mask_q) != '0);
    assign clear_ev = stat_we && (status_d == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:     if (raise_ev) state_d = IRQ_ASSERTED;
            IRQ_ASSERTED: if (clear_ev) state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_ASSERTED);
    end

    p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        raise_ev |=> irq);

    p_only_capture_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !cap_any) |=> !irq);

    p_fall_needs_status_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_we));

endmodule

// File: rtl/msi_irq_collector.sv
module msi_irq_collector
    import msi_irq_pkg::*;
#(
    parameter int unsigned AW     = 64,
    parameter int unsigned DW     = 32,
    parameter int unsigned NVEC   = 32,
    parameter int unsigned REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [REG_AW-1:0] sw_addr,
    input  logic [DW-1:0]     sw_wdata,
    output logic [DW-1:0]     sw_rdata,
    input  logic              in_valid,
    input  logic [AW-1:0]     in_addr,
    input  logic [2:0]        in_size,
    input  logic [DW-1:0]     in_data,
    output logic              irq
);

    localparam int unsigned HALF = AW / 2;

    reg_sel_t        rd_sel, wr_sel;
    logic [HALF-1:0] base_lo_q, base_hi_q;
    logic [AW-1:0]   win_base;
    logic [NVEC-1:0] enable_q, mask_q, status_q, status_d, cap_onehot;

    msi_reg_decode #(.REG_AW(REG_AW)) u_dec (
        .sw_we   (sw_we),
        .sw_addr (sw_addr),
        .rd_sel  (rd_sel),
        .wr_sel  (wr_sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else begin
            if (wr_sel.addr_lo) base_lo_q <= HALF'(sw_wdata);
            if (wr_sel.addr_hi) base_hi_q <= HALF'(sw_wdata);
        end
    end

    assign win_base = {base_hi_q, base_lo_q};

    msi_addr_match #(.AW(AW), .DW(DW), .NVEC(NVEC)) u_match (
        .in_valid   (in_valid),
        .in_addr    (in_addr),
        .in_size    (in_size),
        .in_data    (in_data),
        .win_base   (win_base),
        .enable_q   (enable_q),
        .cap_onehot (cap_onehot)
    );

    msi_vector_bank #(.NVEC(NVEC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (wr_sel.enable),
        .mask_we    (wr_sel.mask),
        .stat_we    (wr_sel.status),
        .wdata      (NVEC'(sw_wdata)),
        .cap_onehot (cap_onehot),
        .enable_q   (enable_q),
        .mask_q     (mask_q),
        .status_q   (status_q),
        .status_d   (status_d)
    );

    msi_irq_fsm #(.NVEC(NVEC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_any  (|cap_onehot),
        .stat_we  (wr_sel.status),
        .status_d (status_d),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    always_comb begin
        sw_rdata = '0;
        if (rd_sel.status)  sw_rdata = DW'(status_q);
        if (rd_sel.enable)  sw_rdata = DW'(enable_q);
        if (rd_sel.mask)    sw_rdata = DW'(mask_q);
        if (rd_sel.addr_lo) sw_rdata = DW'(base_lo_q);
        if (rd_sel.addr_hi) sw_rdata = DW'(base_hi_q);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && status_q == '0 && enable_q == '0));

endmodule

// File: tb/msi_irq_collector_test.sv
module msi_irq_collector_test;

    localparam logic [63:0] BASE = 64'h0000_00AB_F000_0040;
    localparam logic [7:0]  A_ST = 8'h00, A_EN = 8'h04, A_MK = 8'h08,
                            A_LO = 8'h10, A_HI = 8'h14, A_NONE = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [7:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [2:0]  in_size = '0;
    logic [31:0] in_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    msi_irq_collector uut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .in_size(in_size), .in_data(in_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        sw_addr = a;
        #1;
        chk(req, sw_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic inbound(input logic [63:0] a, input logic [2:0] sz, input logic [31:0] v);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_size = sz; in_data = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic both(input logic [31:0] stw, input logic [31:0] v);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = A_ST; sw_wdata = stw;
        in_valid = 1'b1; in_addr = BASE; in_size = 3'd4; in_data = v;
        @(negedge clk);
        sw_we = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 status", A_ST, 0);
        rd_chk("R1 enable", A_EN, 0);
        rd_chk("R1 mask", A_MK, 0);
        rd_chk("R1 addr lo", A_LO, 0);
        rd_chk("R1 addr hi", A_HI, 0);
        irq_chk("R1 irq", 1'b0);
    endtask

    task automatic t_addr;
        sw_write(A_LO, 32'h1234_5678);
        sw_write(A_HI, 32'h0000_00AB);
        rd_chk("R2 lo", A_LO, 32'h1234_5678);
        rd_chk("R2 hi", A_HI, 32'h0000_00AB);
        sw_write(A_LO, BASE[31:0]);
        rd_chk("R2 hi kept", A_HI, 32'h0000_00AB);
        rd_chk("R2 lo new", A_LO, BASE[31:0]);
    endtask

    task automatic t_window_off;
        inbound(BASE, 3'd4, 32'd3);
        rd_chk("R4 window off", A_ST, 0);
        irq_chk("R4 window off irq", 1'b0);
    endtask

    task automatic t_capture;
        sw_write(A_EN, 32'h8000_00F0);
        inbound(BASE, 3'd4, 32'd5);
        rd_chk("R3 capture 5", A_ST, 32'h20);
        irq_chk("R6 raise", 1'b1);
        inbound(BASE, 3'd4, 32'd2);
        rd_chk("R4 disabled vector", A_ST, 32'h20);
        inbound(BASE, 3'd4, 32'd40);
        rd_chk("R5 out of range", A_ST, 32'h20);
        inbound(BASE, 3'd2, 32'd6);
        rd_chk("R5 bad size", A_ST, 32'h20);
        inbound(BASE + 64'd4, 3'd4, 32'd6);
        rd_chk("R5 wrong addr", A_ST, 32'h20);
        inbound(BASE ^ 64'h0000_0001_0000_0000, 3'd4, 32'd6);
        rd_chk("R5 wrong high addr", A_ST, 32'h20);
        inbound(BASE, 3'd4, 32'd31);
        rd_chk("R3 capture 31", A_ST, 32'h8000_0020);
    endtask

    task automatic t_clear;
        sw_write(A_ST, 32'h20);
        rd_chk("R9 partial", A_ST, 32'h8000_0000);
        irq_chk("R9 partial keeps irq", 1'b1);
        sw_write(A_ST, 32'h8000_0000);
        rd_chk("R8 cleared", A_ST, 0);
        irq_chk("R9 drop on zero", 1'b0);
        sw_write(A_ST, 32'h1);
        rd_chk("R8 toggle sets", A_ST, 32'h1);
        irq_chk("R6 write does not raise", 1'b0);
        sw_write(A_ST, 32'h1);
        rd_chk("R8 toggle back", A_ST, 0);
    endtask

    task automatic t_mask;
        sw_write(A_MK, 32'h40);
        inbound(BASE, 3'd4, 32'd6);
        rd_chk("R7 masked captured", A_ST, 32'h40);
        irq_chk("R7 masked no irq", 1'b0);
        sw_write(A_MK, 32'h0);
        irq_chk("R6 unmask no raise", 1'b0);
        inbound(BASE, 3'd4, 32'd4);
        irq_chk("R6 raise after unmask", 1'b1);
        sw_write(A_MK, 32'hFFFF_FFFF);
        irq_chk("R9 mask keeps irq", 1'b1);
        sw_write(A_ST, 32'h50);
        irq_chk("R9 clear drops", 1'b0);
        sw_write(A_MK, 32'h0);
    endtask

    task automatic t_same_cycle;
        inbound(BASE, 3'd4, 32'd7);
        rd_chk("R3 capture 7", A_ST, 32'h80);
        both(32'h80, 32'd7);
        rd_chk("R10 flip then set same", A_ST, 32'h80);
        irq_chk("R10 irq held", 1'b1);
        both(32'h80, 32'd4);
        rd_chk("R10 flip then set other", A_ST, 32'h10);
        irq_chk("R10 irq still", 1'b1);
        sw_write(A_ST, 32'h10);
        irq_chk("R9 final clear", 1'b0);
    endtask

    task automatic t_regmap;
        sw_write(A_NONE, 32'hFFFF_FFFF);
        rd_chk("R11 unused read", A_NONE, 0);
        rd_chk("R11 enable intact", A_EN, 32'h8000_00F0);
        rd_chk("R11 mask intact", A_MK, 0);
        rd_chk("R11 status intact", A_ST, 0);
        rd_chk("R11 hi intact", A_HI, 32'h0000_00AB);
        sw_write(A_EN, 32'h0);
        inbound(BASE, 3'd4, 32'd5);
        rd_chk("R4 enable zero", A_ST, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr();
        t_window_off();
        t_capture();
        t_clear();
        t_mask();
        t_same_cycle();
        t_regmap();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule